// File: doc/BRIEF.md
# Optimal-Replacement Occupancy Trainer

This block watches a stream of cache accesses and works out, after the fact, whether an ideal offline replacement policy would have kept each line. The ideal policy is the one that, on a miss, throws out the line whose next use lies furthest ahead. The block finds these decisions online. It keeps a short history of time slots, newest first. Each slot holds the PC, the address tag, a reuse flag and an occupancy count. The occupancy count is the number of lines the ideal cache holds live across that slot.

When a tag is used again, the trainer looks at the slots from the tag's most recent earlier access up to the newest slot. If every occupancy in that span is below the modelled associativity, the ideal cache could have held the line. The earlier access is then labelled cached and the span's occupancies rise by one. If any slot in the span is already at capacity, the label is not-cached and the occupancies stay as they are. When the history is full and a new slot is needed, the oldest slot is dropped. If that slot was never reused, its PC gets a not-cached label.

Only demand loads and stores train the block. Writebacks and prefetches are accepted and thrown away. Labels leave through a valid/ready stream. The access stream is also valid/ready. While any label is waiting, acc_ready stays low. A label waiting on a low lbl_ready holds its PC and verdict unchanged.

Top module: `otr_trainer`

## Requirements
- R1: After reset, lbl_valid is low, acc_ready is high and the history is empty, so the first access of any tag finds no match.
- R2: An access with acc_kind 2 (writeback) or 3 (prefetch) is consumed without producing a label and without changing the history. Kind 0 is a load and kind 1 is a store; both are demand kinds.
- R3: When a demand access matches a stored tag and every occupancy from the matched slot through the newest slot is below CAP, a label with cached=1 and the matched slot's PC is emitted. Each of those occupancies also rises by one.
- R4: When a demand access matches a stored tag and any occupancy in that span equals CAP, a label with cached=0 and the matched slot's PC is emitted, and no occupancy changes. No occupancy ever exceeds CAP.
- R5: The tag search covers valid slots only and uses the newest matching slot.
- R6: Every demand access becomes the newest slot, with occupancy zero and its own PC and tag.
- R7: When a demand access arrives with DEPTH slots already filled, the oldest slot is dropped. If it was never matched by a later access, a label with cached=0 and its PC is emitted. If it was matched, no label is emitted for it.
- R8: When one access yields both a reuse label and a retire label, the reuse label is presented first.
- R9: acc_ready is low exactly while a label is pending. A label presented with lbl_ready low keeps lbl_pc and lbl_cached stable until it is taken.
- R10: A demand access whose tag has no match, and that retires nothing, emits no label.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Trainer can take an access (no label pending) |
| acc_kind | input | 2 | 0 load, 1 store, 2 writeback, 3 prefetch |
| acc_pc | input | PC_W | PC of the access |
| acc_tag | input | TAG_W | Address tag of the access |
| lbl_valid | output | 1 | Label presented |
| lbl_ready | input | 1 | Consumer takes the label |
| lbl_pc | output | PC_W | PC the label applies to |
| lbl_cached | output | 1 | 1: ideal policy keeps the line, 0: bypass |

## Verification
The assertions check on every cycle that label contents hold under back-pressure and that a writeback or prefetch leaves the history and the label stream alone. They also check that occupancy never exceeds capacity, that a new slot starts at zero, and that dropping an unreused oldest slot raises a not-cached label. The bench's scenarios and its behavioural reference model are needed for the rest. These cover the values of reuse verdicts over spans of different lengths, the choice of the newest match among repeated tags, and the ordering of a reuse label ahead of a retire label from the same access.

// File: rtl/otr_pkg.sv
package otr_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_WBACK = 2'd2,
    ACC_PREF  = 2'd3
  } acc_kind_e;

  function automatic logic is_demand(input logic [1:0] kind);
    return (kind == ACC_LOAD) || (kind == ACC_STORE);
  endfunction
endpackage

// File: rtl/otr_match.sv
module otr_match #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  // slot 0 is newest; scan from oldest so the lowest matching index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (valid[i] && (tags[i] == key)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/otr_occ_check.sv
module otr_occ_check #(
  parameter int DEPTH = 16,
  parameter int CAP   = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(CAP + 1)
) (
  input  logic                        en,
  input  logic [DEPTH-1:0][OCC_W-1:0] occ,
  input  logic [IDX_W-1:0]            upto,
  output logic                        room,
  output logic [DEPTH-1:0]            inc_mask
);
  logic [DEPTH-1:0] in_span;
  logic [DEPTH-1:0] at_cap;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign in_span[g] = (IDX_W'(g) <= upto);
    assign at_cap[g]  = (occ[g] >= OCC_W'(CAP));
  end

  assign room     = ~|(in_span & at_cap);
  assign inc_mask = (en && room) ? in_span : '0;
endmodule

// File: rtl/otr_label_q.sv
module otr_label_q #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            a_v,
  input  logic [PC_W-1:0] a_pc,
  input  logic            a_c,
  input  logic            b_v,
  input  logic [PC_W-1:0] b_pc,
  input  logic            b_c,
  output logic            empty,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_pc,
  output logic            out_cached
);
  logic            v0, v1, c0, c1;
  logic [PC_W-1:0] pc0, pc1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0 <= 1'b0; v1 <= 1'b0; c0 <= 1'b0; c1 <= 1'b0;
      pc0 <= '0;  pc1 <= '0;
    end else if (push) begin
      v0 <= a_v; pc0 <= a_pc; c0 <= a_c;
      v1 <= b_v; pc1 <= b_pc; c1 <= b_c;
    end else if (v0 && out_ready) begin
      v0 <= v1; pc0 <= pc1; c0 <= c1;
      v1 <= 1'b0;
    end
  end

  assign empty      = !v0;
  assign out_valid  = v0;
  assign out_pc     = pc0;
  assign out_cached = c0;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_cached)));
endmodule

// File: rtl/otr_trainer.sv
module otr_trainer #(
  parameter int PC_W  = 16,
  parameter int TAG_W = 12,
  parameter int DEPTH = 16,
  parameter int CAP   = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [1:0]       acc_kind,
  input  logic [PC_W-1:0]  acc_pc,
  input  logic [TAG_W-1:0] acc_tag,
  output logic             lbl_valid,
  input  logic             lbl_ready,
  output logic [PC_W-1:0]  lbl_pc,
  output logic             lbl_cached
);
  import otr_pkg::*;

  logic [DEPTH-1:0]             h_valid, h_used;
  logic [DEPTH-1:0][PC_W-1:0]   h_pc;
  logic [DEPTH-1:0][TAG_W-1:0]  h_tag;
  logic [DEPTH-1:0][OCC_W-1:0]  h_occ;

  logic             q_empty, dem_acc, hit, room;
  logic [IDX_W-1:0] hit_idx;
  logic [DEPTH-1:0] inc_mask, used_upd;
  logic [DEPTH-1:0][OCC_W-1:0] occ_upd;
  logic             retire_lbl;

  assign acc_ready = q_empty;
  assign dem_acc   = acc_valid && acc_ready && is_demand(acc_kind);

  otr_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_match (
    .valid(h_valid), .tags(h_tag), .key(acc_tag), .hit(hit), .idx(hit_idx)
  );

  otr_occ_check #(.DEPTH(DEPTH), .CAP(CAP)) u_occ (
    .en(dem_acc && hit), .occ(h_occ), .upto(hit_idx), .room(room), .inc_mask(inc_mask)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_upd
    assign occ_upd[g]  = h_occ[g] + OCC_W'(inc_mask[g]);
    assign used_upd[g] = h_used[g] | (hit && (hit_idx == IDX_W'(g)));
  end

  assign retire_lbl = h_valid[DEPTH-1] && !used_upd[DEPTH-1];

  // history: slot 0 newest, shifts toward DEPTH-1 on each demand access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_valid <= '0;
      h_used  <= '0;
      h_pc    <= '0;
      h_tag   <= '0;
      h_occ   <= '0;
    end else if (dem_acc) begin
      h_valid[0] <= 1'b1;
      h_used[0]  <= 1'b0;
      h_pc[0]    <= acc_pc;
      h_tag[0]   <= acc_tag;
      h_occ[0]   <= '0;
      for (int i = 1; i < DEPTH; i++) begin
        h_valid[i] <= h_valid[i-1];
        h_used[i]  <= used_upd[i-1];
        h_pc[i]    <= h_pc[i-1];
        h_tag[i]   <= h_tag[i-1];
        h_occ[i]   <= occ_upd[i-1];
      end
    end
  end

  logic            a_v, b_v, a_c, b_c;
  logic [PC_W-1:0] a_pc, b_pc;

  // reuse label goes first; a retire label follows it or stands alone
  always_comb begin
    a_v = 1'b0; a_pc = '0; a_c = 1'b0;
    b_v = 1'b0; b_pc = '0; b_c = 1'b0;
    if (hit) begin
      a_v = 1'b1; a_pc = h_pc[hit_idx]; a_c = room;
      b_v = retire_lbl; b_pc = h_pc[DEPTH-1];
    end else if (retire_lbl) begin
      a_v = 1'b1; a_pc = h_pc[DEPTH-1];
    end
  end

  otr_label_q #(.PC_W(PC_W)) u_lq (
    .clk(clk), .rst_n(rst_n), .push(dem_acc),
    .a_v(a_v), .a_pc(a_pc), .a_c(a_c),
    .b_v(b_v), .b_pc(b_pc), .b_c(b_c),
    .empty(q_empty),
    .out_valid(lbl_valid), .out_ready(lbl_ready),
    .out_pc(lbl_pc), .out_cached(lbl_cached)
  );

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !is_demand(acc_kind)) |=>
      (!lbl_valid && $stable(h_valid) && $stable(h_tag) && $stable(h_occ)));

  for (genvar g = 0; g < DEPTH; g++) begin : g_cap
    p_occ_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      h_occ[g] <= OCC_W'(CAP));
  end

  p_newest_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dem_acc |=> (h_valid[0] && h_occ[0] == '0 && h_tag[0] == $past(acc_tag)));

  p_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_acc && h_valid[DEPTH-1] && !h_used[DEPTH-1] && !hit) |=>
      (lbl_valid && !lbl_cached && lbl_pc == $past(h_pc[DEPTH-1])));
endmodule

// File: tb/otr_trainer_tb.sv
module otr_trainer_tb;
  localparam int PC_W = 16, TAG_W = 12, DEPTH = 16, CAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, lbl_ready = 1'b0;
  logic [1:0] acc_kind = '0;
  logic [PC_W-1:0] acc_pc = '0;
  logic [TAG_W-1:0] acc_tag = '0;
  logic acc_ready, lbl_valid, lbl_cached;
  logic [PC_W-1:0] lbl_pc;

  always #2 clk = ~clk;

  otr_trainer #(.PC_W(PC_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_kind(acc_kind), .acc_pc(acc_pc), .acc_tag(acc_tag),
    .lbl_valid(lbl_valid), .lbl_ready(lbl_ready), .lbl_pc(lbl_pc), .lbl_cached(lbl_cached)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model: history newest at index 0
  int m_tag[$], m_pc[$], m_occ[$];
  bit m_used[$];
  int e_pc[$];
  bit e_c[$];
  string e_r[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(bit v, int k, int pc, int tag, bit rdy);
    bit acc = v && (e_pc.size() == 0);
    if (e_pc.size() > 0 && rdy) begin
      void'(e_pc.pop_front()); void'(e_c.pop_front()); void'(e_r.pop_front());
    end
    if (acc && k < 2) begin
      int m = -1;
      for (int i = 0; i < m_tag.size(); i++)
        if (m_tag[i] == tag) begin m = i; break; end
      if (m >= 0) begin
        bit full = 0;
        for (int j = 0; j <= m; j++) if (m_occ[j] == CAP) full = 1;
        if (!full) begin
          for (int j = 0; j <= m; j++) m_occ[j]++;
          e_pc.push_back(m_pc[m]); e_c.push_back(1); e_r.push_back("R3");
        end else begin
          e_pc.push_back(m_pc[m]); e_c.push_back(0); e_r.push_back("R4");
        end
        m_used[m] = 1;
      end
      if (m_tag.size() == DEPTH) begin
        if (!m_used[DEPTH-1]) begin
          e_pc.push_back(m_pc[DEPTH-1]); e_c.push_back(0); e_r.push_back("R7");
        end
        void'(m_tag.pop_back()); void'(m_pc.pop_back());
        void'(m_occ.pop_back()); void'(m_used.pop_back());
      end
      m_tag.push_front(tag); m_pc.push_front(pc);
      m_occ.push_front(0); m_used.push_front(0);
    end
  endtask

  task automatic cyc(bit v, int k, int pc, int tag, bit rdy);
    @(negedge clk);
    chk(acc_ready == (e_pc.size() == 0), "R9 acc_ready", acc_ready, e_pc.size() == 0);
    chk(lbl_valid == (e_pc.size() > 0), e_pc.size() > 0 ? e_r[0] : "R10 lbl_valid",
        lbl_valid, e_pc.size() > 0);
    if (lbl_valid && e_pc.size() > 0) begin
      chk(lbl_pc == PC_W'(e_pc[0]), e_r[0], lbl_pc, e_pc[0]);
      chk(lbl_cached == e_c[0], e_r[0], lbl_cached, e_c[0]);
    end
    acc_valid = v; acc_kind = 2'(k); acc_pc = PC_W'(pc); acc_tag = TAG_W'(tag);
    lbl_ready = rdy;
    model_step(v, k, pc, tag, rdy);
  endtask

  task automatic drain();
    while (e_pc.size() > 0) cyc(0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(acc_ready == 1'b1, "R1 acc_ready", acc_ready, 1);
    chk(lbl_valid == 1'b0, "R1 lbl_valid", lbl_valid, 0);
    // R10 / R6: fresh tag, no label
    cyc(1, 0, 11, 5, 0);
    // R2: writeback and prefetch of same tag ignored
    cyc(1, 2, 12, 5, 0);
    cyc(1, 3, 13, 5, 0);
    // R3: reuse -> cached, held under back-pressure (R9)
    cyc(1, 1, 14, 5, 0);
    cyc(1, 0, 15, 6, 0);
    cyc(1, 0, 15, 6, 0);
    drain();
    // R5: repeated tag, newest match; R4 saturation through interleaving
    for (int i = 0; i < 8; i++) begin
      cyc(1, i % 2, 20 + i, 7 + (i % 3), 1);
      drain();
    end
    // R7 / R8: fill history, reuse middle entry while oldest is unreused
    for (int i = 0; i < DEPTH; i++) begin cyc(1, 0, 100 + i, 100 + i, 1); drain(); end
    cyc(1, 0, 200, 110, 0);
    cyc(0, 0, 0, 0, 0);
    drain();
    // mixed random traffic
    for (int n = 0; n < 4000; n++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 999),
          $urandom_range(0, 9), $urandom_range(0, 2) != 0);
    drain();
    cyc(0, 0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule